// File: doc/BRIEF.md
# Tag page memory access controller

This block stands between a command decoder and a page-organised non-volatile store. The store is modelled here as a register array of 48 words, 32 bits each. The decoder presents one command per cycle. The command carries an opcode, a page number and a 16-byte payload. Exactly one cycle later the block answers with a 4-bit result code and, for reads, 16 bytes of page data.

The lowest pages hold a factory-set 7-byte serial number and its two check bytes. These pages can be read but never written. The upper half of page 2 holds sixteen write-lock bits. A lock bit only ever goes from 0 to 1, and it blocks writes to its group of pages but never blocks reads. Page 3 is a one-time-programmable word: it only ever gains ones. Pages 4 to 47 are plain user pages.

Two write forms exist. The plain write commits the low 4 bytes of the payload. The compatibility write carries a full 16-byte payload, keeps the 4 least-significant bytes and drops the other 12.

Top module: `tag_page_ctrl`

## Requirements
- R1: After reset, `rsp_valid` is low and every page from 4 to 47 reads as zero, since a cell that was never written reads 0.
- R2: After reset, page 0 holds serial bytes s0, s1 and s2 in its bits 7:0, 15:8 and 23:16, and check byte C0 = 0x88^s0^s1^s2 in bits 31:24. Page 1 holds s3 to s6, with s3 in bits 7:0. Page 2 holds check byte C1 = s3^s4^s5^s6 in bits 7:0 and zeros in bits 31:8. The serial value is a parameter, with s0 in its bits 7:0.
- R3: A read (opcode 0) of page p, with p below 48, returns result code 0xA. It also returns the 128-bit word {page p+3, page p+2, page p+1, page p}, where each index is taken modulo 48, so page 0 follows page 47. The response appears in the cycle after the command.
- R4: A read of page 48 or higher returns result code 0x0 and all-zero data.
- R5: A plain write (opcode 1) to an unlocked page from 4 to 47 stores payload bits 31:0 and returns 0xA in the next cycle. The write is visible to a read issued in that next cycle. Write responses carry zero data.
- R6: A compatibility write (opcode 2) behaves like a plain write. Payload bits 127:32 have no effect on the store.
- R7: A write to page 3 that is not refused stores the old value ORed with payload bits 31:0, so no bit of page 3 ever returns to 0.
- R8: A write to page 2 that is not refused ORs payload bits 31:16 into page 2 bits 31:16 and leaves bits 15:0 unchanged. Lock bit k is page 2 bit 16+k. For k from 1 to 15, bit k locks pages 3k to 3k+2. Bit 0 locks page 2 itself. Lock bits are never cleared.
- R9: A write to page 0 or page 1, to a locked page, or to page 48 or higher is refused. It returns 0x0 and leaves the store unchanged.
- R10: Lock bits never refuse a read. A read of a locked page returns its data with code 0xA.
- R11: `rsp_valid` is high exactly in the cycle after each cycle in which `cmd_valid` is high. Opcode 3 is reserved and returns 0x0 without touching the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; reloads the serial pages and clears all others |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_op | input | 2 | 0 read, 1 plain write, 2 compatibility write, 3 reserved |
| cmd_page | input | 8 | Page number |
| cmd_data | input | 128 | Write payload; bits 31:0 are the committed word |
| rsp_valid | output | 1 | Result strobe, one cycle after the command |
| rsp_code | output | 4 | 0xA accepted, 0x0 refused |
| rsp_data | output | 128 | Read data, page p in bits 31:0; zero for writes and refusals |

## Verification
The lock decision and the lock update can fall in the same cycle when a write to page 2 raises bit 0. That command is judged against the lock word as it stood before the write, so it is accepted. The command immediately behind it, another write to page 2, must then be refused. The bench provokes this case by issuing the two commands back to back. A scoreboard that tracks the lock state itself expects 0xA for the first and 0x0 for the second, and a read of page 2 then confirms that the second payload left no trace.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_COMPAT = 2'd2,
    OP_RSVD   = 2'd3
  } tpc_op_e;

  typedef enum logic [1:0] {
    PG_SERIAL,
    PG_LOCK,
    PG_OTP,
    PG_USER
  } pg_kind_e;

  localparam logic [3:0] CODE_ACK = 4'hA;
  localparam logic [3:0] CODE_NAK = 4'h0;

  // first check byte: cascade tag folded with the three low serial bytes
  function automatic logic [7:0] check_low(input logic [55:0] sn);
    return 8'h88 ^ sn[7:0] ^ sn[15:8] ^ sn[23:16];
  endfunction

  // second check byte: fold of the four upper serial bytes
  function automatic logic [7:0] check_high(input logic [55:0] sn);
    return sn[31:24] ^ sn[39:32] ^ sn[47:40] ^ sn[55:48];
  endfunction

  // power-on content of page p
  function automatic logic [WORD_W-1:0] init_page(input int p, input logic [55:0] sn,
                                                  input int lock_page);
    logic [WORD_W-1:0] w;
    w = '0;
    if (p == 0)              w = {check_low(sn), sn[23:0]};
    else if (p == 1)         w = sn[55:24];
    else if (p == lock_page) w = {24'h0, check_high(sn)};
    return w;
  endfunction

  // set-only merge of selected bits
  function automatic logic [WORD_W-1:0] set_only(input logic [WORD_W-1:0] old_w,
                                                 input logic [WORD_W-1:0] new_w,
                                                 input logic [WORD_W-1:0] mask);
    return old_w | (new_w & mask);
  endfunction

endpackage

// File: rtl/tpc_addr_map.sv
module tpc_addr_map #(
  parameter int NUM_PAGES      = 48,
  parameter int ADDR_W         = 8,
  parameter int LOCK_PAGE      = 2,
  parameter int OTP_PAGE       = 3,
  parameter int PAGES_PER_LOCK = 3,
  parameter int LOCK_BITS      = 16
) (
  input  logic [ADDR_W-1:0]    page,
  input  logic [LOCK_BITS-1:0] lock_bits,
  output logic                 in_range,
  output tpc_pkg::pg_kind_e    kind,
  output logic                 locked
);
  import tpc_pkg::*;

  localparam int LIDX_W = $clog2(LOCK_BITS);

  logic [ADDR_W-1:0] group;

  assign in_range = page < ADDR_W'(NUM_PAGES);
  assign group    = page / ADDR_W'(PAGES_PER_LOCK);

  always_comb begin
    if (page < ADDR_W'(LOCK_PAGE))       kind = PG_SERIAL;
    else if (page == ADDR_W'(LOCK_PAGE)) kind = PG_LOCK;
    else if (page == ADDR_W'(OTP_PAGE))  kind = PG_OTP;
    else                                 kind = PG_USER;
  end

  always_comb begin
    locked = 1'b1;
    case (kind)
      PG_SERIAL: locked = 1'b1;
      PG_LOCK:   locked = lock_bits[0];
      default:   locked = (group < ADDR_W'(LOCK_BITS)) ? lock_bits[group[LIDX_W-1:0]] : 1'b1;
    endcase
  end

endmodule

// File: rtl/tpc_merge.sv
module tpc_merge #(
  parameter int LOCK_BITS = 16
) (
  input  tpc_pkg::pg_kind_e kind,
  input  logic [31:0]       old_word,
  input  logic [31:0]       new_word,
  output logic [31:0]       merged
);
  import tpc_pkg::*;

  localparam logic [31:0] LOCK_MASK = {{LOCK_BITS{1'b1}}, {(32 - LOCK_BITS){1'b0}}};

  always_comb begin
    case (kind)
      PG_LOCK: merged = set_only(old_word, new_word, LOCK_MASK);
      PG_OTP:  merged = set_only(old_word, new_word, 32'hFFFF_FFFF);
      PG_USER: merged = new_word;
      default: merged = old_word;
    endcase
  end

endmodule

// File: rtl/tpc_store.sv
module tpc_store #(
  parameter int          NUM_PAGES = 48,
  parameter int          ADDR_W    = 8,
  parameter int          READ_SPAN = 4,
  parameter int          LOCK_PAGE = 2,
  parameter int          OTP_PAGE  = 3,
  parameter logic [55:0] SERIAL    = 56'hC7B6A594837261
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [31:0]               wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [READ_SPAN*32-1:0]   rdata,
  output logic [31:0]               wold,
  output logic [31:0]               sn_word0,
  output logic [31:0]               sn_word1,
  output logic [31:0]               lock_page_word,
  output logic [31:0]               otp_page_word
);
  import tpc_pkg::*;

  localparam int               PIDX_W = $clog2(NUM_PAGES);
  localparam logic [ADDR_W:0]  NP_EXT = (ADDR_W + 1)'(NUM_PAGES);

  logic [31:0] mem [NUM_PAGES];

  function automatic logic [PIDX_W-1:0] wrap_index(input logic [ADDR_W-1:0] base,
                                                   input int unsigned step);
    logic [ADDR_W:0] s;
    s = {1'b0, base} + (ADDR_W + 1)'(step);
    if (s >= NP_EXT) s = s - NP_EXT;
    if (s >= NP_EXT) s = '0;
    return s[PIDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++) mem[p] <= init_page(p, SERIAL, LOCK_PAGE);
    end else if (we) begin
      mem[waddr[PIDX_W-1:0]] <= wdata;
    end
  end

  for (genvar k = 0; k < READ_SPAN; k++) begin : g_rd
    assign rdata[k*32 +: 32] = mem[wrap_index(raddr, k)];
  end

  assign wold           = ({1'b0, waddr} < NP_EXT) ? mem[waddr[PIDX_W-1:0]] : '0;
  assign sn_word0       = mem[0];
  assign sn_word1       = mem[1];
  assign lock_page_word = mem[LOCK_PAGE];
  assign otp_page_word  = mem[OTP_PAGE];

endmodule

// File: rtl/tag_page_ctrl.sv
module tag_page_ctrl #(
  parameter int          NUM_PAGES      = 48,
  parameter int          ADDR_W         = 8,
  parameter int          READ_SPAN      = 4,
  parameter int          PAYLOAD_BYTES  = 16,
  parameter int          LOCK_PAGE      = 2,
  parameter int          OTP_PAGE       = 3,
  parameter int          PAGES_PER_LOCK = 3,
  parameter logic [55:0] SERIAL         = 56'hC7B6A594837261
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [ADDR_W-1:0]         cmd_page,
  input  logic [PAYLOAD_BYTES*8-1:0] cmd_data,
  output logic                      rsp_valid,
  output logic [3:0]                rsp_code,
  output logic [READ_SPAN*32-1:0]   rsp_data
);
  import tpc_pkg::*;

  localparam int LOCK_BITS = 16;
  localparam int RD_W      = READ_SPAN * 32;

  tpc_op_e           op;
  pg_kind_e          kind;
  logic              in_range;
  logic              locked;
  logic [31:0]       wold;
  logic [31:0]       commit_word;
  logic [RD_W-1:0]   rd_word;
  logic [31:0]       sn_word0;
  logic [31:0]       sn_word1;
  logic [31:0]       lock_page_word;
  logic [31:0]       otp_word;
  logic [LOCK_BITS-1:0] lock_word;
  logic [15:0]       lock_low_half;

  // named internal events
  logic wr_req;
  logic wr_commit;
  logic wr_refuse;
  logic rd_accept;

  assign op            = tpc_op_e'(cmd_op);
  assign lock_word     = lock_page_word[31:32-LOCK_BITS];
  assign lock_low_half = lock_page_word[15:0];

  tpc_addr_map #(
    .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .LOCK_PAGE(LOCK_PAGE),
    .OTP_PAGE(OTP_PAGE), .PAGES_PER_LOCK(PAGES_PER_LOCK), .LOCK_BITS(LOCK_BITS)
  ) u_map (
    .page(cmd_page), .lock_bits(lock_word),
    .in_range(in_range), .kind(kind), .locked(locked)
  );

  tpc_merge #(.LOCK_BITS(LOCK_BITS)) u_merge (
    .kind(kind), .old_word(wold), .new_word(cmd_data[31:0]), .merged(commit_word)
  );

  assign wr_req    = cmd_valid && (op == OP_WRITE || op == OP_COMPAT);
  assign wr_commit = wr_req && in_range && (kind != PG_SERIAL) && !locked;
  assign wr_refuse = wr_req && !wr_commit;
  assign rd_accept = cmd_valid && (op == OP_READ) && in_range;

  tpc_store #(
    .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .READ_SPAN(READ_SPAN),
    .LOCK_PAGE(LOCK_PAGE), .OTP_PAGE(OTP_PAGE), .SERIAL(SERIAL)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_commit), .waddr(cmd_page), .wdata(commit_word),
    .raddr(cmd_page), .rdata(rd_word), .wold(wold),
    .sn_word0(sn_word0), .sn_word1(sn_word1),
    .lock_page_word(lock_page_word), .otp_page_word(otp_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= CODE_NAK;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_code  <= (rd_accept || wr_commit) ? CODE_ACK : CODE_NAK;
      rsp_data  <= rd_accept ? rd_word : '0;
    end
  end

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int NUM_PAGES = 48,
  parameter int ADDR_W    = 8,
  parameter int OTP_PAGE  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_page,
  input logic [127:0]      cmd_data,
  input logic              wr_commit,
  input logic              wr_refuse,
  input logic [31:0]       commit_word,
  input logic              rsp_valid,
  input logic [3:0]        rsp_code,
  input logic [15:0]       lock_word,
  input logic [15:0]       lock_low_half,
  input logic [31:0]       otp_word,
  input logic [31:0]       sn_word0,
  input logic [31:0]       sn_word1
);

  assert_refuse_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refuse |=> (rsp_valid && rsp_code == 4'h0));

  assert_commit_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (rsp_valid && rsp_code == 4'hA));

  assert_serial_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(sn_word0) && $stable(sn_word1) && $stable(lock_low_half)));

  assert_otp_set_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((otp_word & $past(otp_word)) == $past(otp_word)));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_word & $past(lock_word)) == $past(lock_word)));

  assert_read_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && cmd_page < ADDR_W'(NUM_PAGES)) |=> (rsp_code == 4'hA));

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  // two compat commits to one user page differing only in the dropped bytes store the same word
  assert_compat_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wr_commit && cmd_op == 2'd2 && $past(wr_commit) && $past(cmd_op) == 2'd2 &&
     $past(cmd_page) == cmd_page && cmd_page > ADDR_W'(OTP_PAGE) &&
     $past(cmd_data[31:0]) == cmd_data[31:0] && $past(cmd_data[127:32]) != cmd_data[127:32])
    |-> (commit_word == $past(commit_word)));

endmodule

bind tag_page_ctrl tpc_checker #(
  .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .OTP_PAGE(OTP_PAGE)
) u_tpc_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_page(cmd_page), .cmd_data(cmd_data), .wr_commit(wr_commit),
  .wr_refuse(wr_refuse), .commit_word(commit_word), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .lock_word(lock_word), .lock_low_half(lock_low_half),
  .otp_word(otp_word), .sn_word0(sn_word0), .sn_word1(sn_word1)
);

// File: tb/test_tag_page_ctrl.sv
`timescale 1ns/1ps
module test_tag_page_ctrl;

  localparam logic [55:0] SN = 56'hC7B6A594837261;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'd0;
  logic [7:0]   cmd_page = 8'd0;
  logic [127:0] cmd_data = '0;
  logic         rsp_valid;
  logic [3:0]   rsp_code;
  logic [127:0] rsp_data;

  always #2 clk = ~clk;

  tag_page_ctrl #(.SERIAL(SN)) i_tag_page_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0]   q_code [$];
  logic [127:0] q_data [$];
  string        q_req  [$];

  logic [31:0] mdl [48];

  function automatic bit mdl_locked(input int p);
    if (p < 2) return 1'b1;
    if (p == 2) return mdl[2][16];
    return mdl[2][16 + p / 3];
  endfunction

  // driver: predicts the result, queues it and drives one command
  task automatic issue(input logic [1:0] op, input int page, input logic [127:0] d,
                       input string req);
    logic [3:0]   c;
    logic [127:0] r;
    logic [31:0]  w;
    c = 4'h0;
    r = '0;
    w = d[31:0];
    if (op == 2'd0) begin
      if (page < 48) begin
        c = 4'hA;
        for (int k = 0; k < 4; k++) r[k*32 +: 32] = mdl[(page + k) % 48];
      end
    end else if (op != 2'd3) begin
      if (page < 48 && !mdl_locked(page)) begin
        c = 4'hA;
        if (page == 2)      mdl[2] = mdl[2] | {w[31:16], 16'h0};
        else if (page == 3) mdl[3] = mdl[3] | w;
        else                mdl[page] = w;
      end
    end
    q_code.push_back(c);
    q_data.push_back(r);
    q_req.push_back(req);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_page  = 8'(page);
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = {4{32'hDEAD_0000}};
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        checks++;
        if (q_code.size() == 0) begin
          fails++;
          $display("FAIL R11 unexpected response actual=1 expected=0");
        end else begin
          logic [3:0] ec;
          logic [127:0] ed;
          string rq;
          ec = q_code.pop_front();
          ed = q_data.pop_front();
          rq = q_req.pop_front();
          if (rsp_code !== ec || rsp_data !== ed) begin
            fails++;
            $display("FAIL %s actual=%h/%h expected=%h/%h", rq, rsp_code, rsp_data, ec, ed);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 48; p++) mdl[p] = 32'h0;
    mdl[0] = {8'h88 ^ SN[7:0] ^ SN[15:8] ^ SN[23:16], SN[23:16], SN[15:8], SN[7:0]};
    mdl[1] = {SN[55:48], SN[47:40], SN[39:32], SN[31:24]};
    mdl[2] = {24'h0, SN[31:24] ^ SN[39:32] ^ SN[47:40] ^ SN[55:48]};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 rsp_valid after reset actual=%b expected=0", rsp_valid);
    end

    issue(2'd0, 0,  '0, "R2 serial pages");
    issue(2'd0, 4,  '0, "R1 erased pages");
    issue(2'd0, 44, '0, "R1 erased top pages");
    issue(2'd0, 46, '0, "R3 wrap read");
    issue(2'd0, 48, '0, "R4 read out of range");
    issue(2'd0, 200, '0, "R4 read far out of range");
    issue(2'd1, 10, {96'hFFFF, 32'h1234_5678}, "R5 plain write");
    issue(2'd0, 10, '0, "R5 read back next cycle");
    issue(2'd2, 11, {96'hA5A5_5A5A_FFFF_0000_1111_2222, 32'hCAFE_F00D}, "R6 compat write");
    issue(2'd2, 11, {96'h0123_4567_89AB_CDEF_0000_0001, 32'hCAFE_F00D}, "R6 compat rewrite");
    issue(2'd0, 9, '0, "R6 high bytes dropped");
    issue(2'd1, 3, {96'h0, 32'h0000_00F0}, "R7 otp first");
    issue(2'd1, 3, {96'h0, 32'h0000_000F}, "R7 otp second");
    issue(2'd2, 3, {96'h0, 32'h0000_0000}, "R7 otp zero write");
    issue(2'd0, 3, '0, "R7 otp accumulated");
    issue(2'd1, 0, {96'h0, 32'hFFFF_FFFF}, "R9 serial page 0 write");
    issue(2'd2, 1, {96'h0, 32'h0000_0000}, "R9 serial page 1 write");
    issue(2'd1, 50, {96'h0, 32'h1}, "R9 write out of range");
    issue(2'd0, 0, '0, "R9 serial unchanged");
    issue(2'd1, 2, {96'h0, 32'h0008_FFFF}, "R8 set lock bit 3");
    issue(2'd0, 2, '0, "R8 low half kept");
    issue(2'd1, 10, {96'h0, 32'h9999_9999}, "R9 locked page write");
    issue(2'd2, 9,  {96'h0, 32'h8888_8888}, "R9 locked page compat write");
    issue(2'd0, 9, '0, "R10 locked pages readable");
    issue(2'd1, 12, {96'h0, 32'h7777_7777}, "R8 page past group open");
    issue(2'd1, 2, {96'h0, 32'h0000_0000}, "R8 lock not cleared");
    issue(2'd3, 5, {96'h0, 32'h5555_5555}, "R11 reserved opcode");
    issue(2'd0, 4, '0, "R11 reserved left store");

    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle cycle actual=%b expected=0", rsp_valid);
    end

    issue(2'd1, 2, {96'h0, 32'h0001_0000}, "R8 lock page self lock");
    issue(2'd1, 2, {96'h0, 32'h0040_0000}, "R9 lock page frozen");
    issue(2'd0, 2, '0, "R8 frozen lock content");
    issue(2'd0, 47, '0, "R3 wrap from last page");

    repeat (3) @(negedge clk);
    checks++;
    if (q_code.size() != 0) begin
      fails++;
      $display("FAIL R11 pending results actual=%0d expected=0", q_code.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule